// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Controller

This block keeps an attached SDRAM's contents alive. A programmable interval counter advances on a timebase tick. When it reaches the compare value, the block asks the main access sequencer for the command bus, issues an auto-refresh command, and then keeps the bus quiet for a programmed recovery time. Software can preload the counter. Loading the compare value minus one makes the next tick trigger a refresh.

When the configuration selects self-refresh, the block asks for the bus in the same way. It then closes all banks with a precharge-all command, waits out the precharge time, and issues the self-refresh command with the clock enable driven low. The clock enable stays low for as long as self-refresh remains selected, and chip standby does not disturb it. When self-refresh is deselected, the clock enable rises and the bus is held quiet for the recovery time. Periodic refresh then resumes from the counter value that was kept while the device was in self-refresh. A power-on reset clears every state, including self-refresh.

The refresh request toward the access sequencer is a valid/ready pair. `ref_req` is the valid. Once raised, it stays high until `ref_gnt` is sampled high with it, and no other action withdraws it. The refresh or precharge-all command appears in the cycle after the grant cycle. The sequencer must grant only between bursts. The block never asserts back-pressure on anything of its own.

Top module: `sdram_refresh_ctrl`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, the bus shows a deselect (CS_n/RAS_n/CAS_n/WE_n = H/H/H/H, A10 low), `sd_cke` is high and `ref_req` is low. The interval counter restarts from 0, so after reset a refresh needs exactly `cnt_cmp` ticks.
- R2: The counter advances by one on each clock with `tick` high, but only while `cfg_refresh_en`=1, `cfg_self_mode`=0, `standby`=0 and the device is not in self-refresh. On the tick that brings it to `cnt_cmp`, it clears to 0, and `ref_req` is high in the next cycle.
- R3: A `cnt_wr` cycle loads `cnt_wr_data` into the counter and takes priority over counting that cycle. After a load of `cnt_cmp`-1, a single tick raises a refresh request.
- R4: Once raised, `ref_req` stays high until a cycle with `ref_gnt` high. In the following cycle `ref_req` is low and a command is on the bus.
- R5: An auto-refresh is encoded as L/L/L/H on CS_n/RAS_n/CAS_n/WE_n with `sd_cke` high. It is followed by max(`trc_clocks`,1) deselect cycles with `ref_req` low, and then one idle cycle before any new request.
- R6: With `cfg_refresh_en`=1, `cfg_self_mode`=1 and `cfg_pdown_active`=0, a request is raised. After the grant the bus shows a precharge-all (L/L/H/L with A10 high), then TP_CYC deselect cycles, then the self-refresh command (L/L/L/H with `sd_cke` low), then deselects with `sd_cke` low.
- R7: `standby` does not affect a device in self-refresh (`sd_cke` stays low). It also freezes the interval counter.
- R8: When `cfg_self_mode` or `cfg_refresh_en` falls during self-refresh, `sd_cke` is high in the next cycle. The bus then shows max(`trc_clocks`,1) deselect cycles with no request.
- R9: The counter does not advance in self-refresh. After exit, auto-refresh resumes from the value it held at entry.
- R10: While `cfg_pdown_active`=1, self-refresh entry is held: no request is raised and `sd_cke` stays high. The request appears in the cycle after `cfg_pdown_active` clears. A grant taken while it is high yields an auto-refresh, not a precharge-all.
- R11: A power-on reset during self-refresh returns `sd_cke` high and the bus to deselect.
- R12: With `cfg_refresh_en`=0, ticks are ignored and the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| cfg_refresh_en | input | 1 | Refresh enable |
| cfg_self_mode | input | 1 | 1 selects self-refresh, 0 periodic auto-refresh |
| cfg_pdown_active | input | 1 | SDRAM is in power-down; holds self-refresh entry |
| standby | input | 1 | Chip standby indication |
| tick | input | 1 | Interval timebase pulse |
| cnt_wr | input | 1 | Load strobe for the interval counter |
| cnt_wr_data | input | CNT_W | Counter load value |
| cnt_cmp | input | CNT_W | Interval compare value |
| trc_clocks | input | TRC_W | Recovery clocks after refresh or self-refresh exit |
| ref_req | output | 1 | Refresh request (valid) |
| ref_gnt | input | 1 | Grant from access sequencer (ready) |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a10 | output | 1 | Address bit 10 (all-banks select) |
| sd_cke | output | 1 | SDRAM clock enable |

## Verification
The bench builds the block with CNT_W=6, TRC_W=3 and TP_CYC=2. With these values, every compare value from 2 to 63 and every start value below it can be drawn at random and counted through in a few hundred cycles. The narrow recovery field lets the bench cover a recovery count of 0 (clamped to one cycle) as well as its largest value. The short precharge wait keeps the full entry, hold and exit sequence of self-refresh within a few dozen cycles.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_AREF,
    ST_TRC,
    ST_PALL,
    ST_TPW,
    ST_SREN,
    ST_SELF,
    ST_SREX
  } rf_state_e;

  // Field order: cs_n, ras_n, cas_n, we_n, a10, cke
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
    logic cke;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL     = sd_cmd_t'(6'b1111_0_1);
  localparam sd_cmd_t CMD_PREALL    = sd_cmd_t'(6'b0010_1_1);
  localparam sd_cmd_t CMD_AUTOREF   = sd_cmd_t'(6'b0001_0_1);
  localparam sd_cmd_t CMD_SELFENTER = sd_cmd_t'(6'b0001_0_0);
  localparam sd_cmd_t CMD_SELFHOLD  = sd_cmd_t'(6'b1111_0_0);

endpackage

// File: rtl/sdram_rf_interval_timer.sv
module sdram_rf_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cmp,
  output logic             match
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             adv;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    adv     = run & tick & ~wr_en;
    match   = adv & (cnt_inc == cmp);
    cnt_d   = cnt_q;
    if (wr_en)      cnt_d = wr_data;
    else if (match) cnt_d = '0;
    else if (adv)   cnt_d = cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  counter_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(cnt_q));

  // R3
  preload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !match);

endmodule

// File: rtl/sdram_rf_wait_ctr.sv
module sdram_rf_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign done = (cnt_q <= W'(1));

endmodule

// File: rtl/sdram_rf_sequencer.sv
module sdram_rf_sequencer
  import sdram_refresh_pkg::*;
#(
  parameter int TRC_W  = 4,
  parameter int TP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_self,
  input  logic             cfg_pdown,
  input  logic             match,
  input  logic [TRC_W-1:0] trc_clocks,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             in_self,
  output sd_cmd_t          cmd
);

  localparam int TP_BITS = $clog2(TP_CYC + 1);
  localparam int WAIT_W  = (TRC_W > TP_BITS) ? TRC_W : TP_BITS;

  rf_state_e         state_q, state_d;
  logic              pending_q, pending_d;
  logic              want_self, self_hold;
  logic              wload, wdone;
  logic [WAIT_W-1:0] wval;

  assign want_self = cfg_en & cfg_self & ~cfg_pdown;
  assign self_hold = cfg_en & cfg_self;

  sdram_rf_wait_ctr #(.W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wload),
    .load_val (wval),
    .done     (wdone)
  );

  always_comb begin
    state_d = state_q;
    wload   = 1'b0;
    wval    = WAIT_W'(trc_clocks);
    case (state_q)
      ST_IDLE: if (want_self || pending_q || match) state_d = ST_REQ;
      ST_REQ:  if (ref_gnt) state_d = want_self ? ST_PALL : ST_AREF;
      ST_AREF: begin
        state_d = ST_TRC;
        wload   = 1'b1;
      end
      ST_TRC:  if (wdone) state_d = ST_IDLE;
      ST_PALL: begin
        state_d = ST_TPW;
        wload   = 1'b1;
        wval    = WAIT_W'(TP_CYC);
      end
      ST_TPW:  if (wdone) state_d = ST_SREN;
      ST_SREN: state_d = ST_SELF;
      ST_SELF: if (!self_hold) begin
        state_d = ST_SREX;
        wload   = 1'b1;
      end
      ST_SREX: if (wdone) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign pending_d = (pending_q & (state_q != ST_AREF)) | match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pending_q <= pending_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_AREF: cmd = CMD_AUTOREF;
      ST_PALL: cmd = CMD_PREALL;
      ST_SREN: cmd = CMD_SELFENTER;
      ST_SELF: cmd = CMD_SELFHOLD;
      default: cmd = CMD_DESEL;
    endcase
  end

  assign ref_req = (state_q == ST_REQ);
  assign in_self = (state_q == ST_SREN) || (state_q == ST_SELF);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  // R4
  gnt_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (!cmd.cs_n && !ref_req));

  // R5
  aref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.cs_n && cmd.we_n && cmd.cke) |=> (cmd.cs_n && !ref_req));

  // R7
  self_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.cke && cfg_en && cfg_self) |=> !cmd.cke);

  // R8
  exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd.cke) |=> (cmd.cs_n && !ref_req));

  // R10
  pdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && cfg_pdown) |=> cmd.we_n);

endmodule

// File: rtl/sdram_refresh_ctrl.sv
module sdram_refresh_ctrl
  import sdram_refresh_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TRC_W  = 4,
  parameter int TP_CYC = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cfg_refresh_en,
  input  logic             cfg_self_mode,
  input  logic             cfg_pdown_active,
  input  logic             standby,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic [CNT_W-1:0] cnt_cmp,
  input  logic [TRC_W-1:0] trc_clocks,
  output logic             ref_req,
  input  logic             ref_gnt,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_a10,
  output logic             sd_cke
);

  logic    run, match, in_self;
  sd_cmd_t cmd;

  assign run = cfg_refresh_en & ~cfg_self_mode & ~in_self & ~standby;

  sdram_rf_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (por_n),
    .run     (run),
    .tick    (tick),
    .wr_en   (cnt_wr),
    .wr_data (cnt_wr_data),
    .cmp     (cnt_cmp),
    .match   (match)
  );

  sdram_rf_sequencer #(.TRC_W(TRC_W), .TP_CYC(TP_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (por_n),
    .cfg_en     (cfg_refresh_en),
    .cfg_self   (cfg_self_mode),
    .cfg_pdown  (cfg_pdown_active),
    .match      (match),
    .trc_clocks (trc_clocks),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .in_self    (in_self),
    .cmd        (cmd)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;
  assign sd_a10   = cmd.a10;
  assign sd_cke   = cmd.cke;

endmodule

// File: tb/sdram_refresh_ctrl_test.sv
module sdram_refresh_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 6;
  localparam int TW  = 3;
  localparam int TPC = 2;
  localparam logic [3:0] E_NOP  = 4'b1111;
  localparam logic [3:0] E_PALL = 4'b0010;
  localparam logic [3:0] E_AREF = 4'b0001;

  logic clk = 0, por_n = 0;
  logic cfg_en = 0, cfg_self = 0, cfg_pd = 0, standby = 0, tick = 0;
  logic cnt_wr = 0, ref_gnt = 0;
  logic [CW-1:0] cnt_wr_data = '0, cnt_cmp = '0;
  logic [TW-1:0] trc = '0;
  logic ref_req, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10, sd_cke;
  logic [3:0] bus;
  int checks = 0, fails = 0;
  bit done = 0;

  assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  sdram_refresh_ctrl #(.CNT_W(CW), .TRC_W(TW), .TP_CYC(TPC)) uut (
    .clk(clk), .por_n(por_n), .cfg_refresh_en(cfg_en), .cfg_self_mode(cfg_self),
    .cfg_pdown_active(cfg_pd), .standby(standby), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wr_data(cnt_wr_data), .cnt_cmp(cnt_cmp), .trc_clocks(trc),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a10(sd_a10), .sd_cke(sd_cke));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int need_ticks(int cmpv, int start);
    return cmpv - start;
  endfunction

  function automatic int wait_len(int t);
    return (t < 1) ? 1 : t;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic load_cnt(int v);
    cnt_wr = 1; cnt_wr_data = CW'(v); step(); cnt_wr = 0;
  endtask

  // grant a pending auto-refresh, check command and recovery gap
  task automatic serve_aref(string tag, bit tick_in_gap);
    ref_gnt = 1; step(); ref_gnt = 0;
    chk({tag, " R4 req drop"}, ref_req, 0);
    chk({tag, " R5 aref code"}, bus, E_AREF);
    chk({tag, " R5 aref cke"}, sd_cke, 1);
    if (tick_in_gap) tick = 1;
    for (int i = 0; i < wait_len(trc); i++) begin
      step(); tick = 0;
      chk({tag, " R5 gap nop"}, bus, E_NOP);
      chk({tag, " R5 gap noreq"}, ref_req, 0);
    end
    step();
    chk({tag, " R5 idle"}, ref_req, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cnt_cmp = 5; trc = 3;
    repeat (3) step();
    chk("R1 reset cke", sd_cke, 1);
    chk("R1 reset bus", bus, E_NOP);
    chk("R1 reset req", ref_req, 0);
    por_n = 1; step();
    chk("R1 post bus", bus, E_NOP);
    chk("R1 post a10", sd_a10, 0);

    // R1/R2: from 0, cmp=5 ticks
    cfg_en = 1;
    for (int i = 0; i < need_ticks(5, 0); i++) begin
      pulse_tick();
      chk("R2 count", ref_req, (i == 4) ? 1 : 0);
    end
    // R4: hold without grant
    repeat (3) begin step(); chk("R4 hold", ref_req, 1); end
    // R3 preload during REQ, then tick in gap -> pending
    load_cnt(4);
    serve_aref("R5a", 1);
    step();
    chk("R5 pending req", ref_req, 1);
    serve_aref("R5b", 0);

    // R12: disabled ignores ticks
    cfg_en = 0;
    load_cnt(4);
    repeat (6) begin pulse_tick(); chk("R12 disabled", ref_req, 0); end
    cfg_en = 1;
    pulse_tick();
    chk("R12 kept value R3", ref_req, 1);
    trc = 0;
    serve_aref("R5 trc0", 0);

    // R2/R3 random
    for (int it = 0; it < 20; it++) begin
      int c, s, k;
      c = 2 + int'($urandom % 62);
      s = int'($urandom % c);
      cnt_cmp = CW'(c);
      trc = TW'($urandom % 8);
      load_cnt(s);
      k = need_ticks(c, s);
      for (int i = 0; i < k; i++) begin
        repeat (int'($urandom % 3)) begin step(); chk("R2 gap", ref_req, 0); end
        pulse_tick();
        chk("R2 rand", ref_req, (i == k - 1) ? 1 : 0);
      end
      repeat (int'($urandom % 3)) begin step(); chk("R4 rand hold", ref_req, 1); end
      serve_aref("R5 rand", 0);
    end

    // R7 standby freezes counter
    cnt_cmp = 10; trc = 2;
    load_cnt(9);
    standby = 1;
    repeat (3) begin pulse_tick(); chk("R7 standby freeze", ref_req, 0); end
    standby = 0;
    pulse_tick();
    chk("R7 resume", ref_req, 1);
    serve_aref("R7", 0);

    // R6 self-refresh entry
    load_cnt(9);
    cfg_self = 1; step();
    chk("R6 req", ref_req, 1);
    ref_gnt = 1; step(); ref_gnt = 0;
    chk("R6 pall code", bus, E_PALL);
    chk("R6 pall a10", sd_a10, 1);
    chk("R6 pall cke", sd_cke, 1);
    for (int i = 0; i < TPC; i++) begin
      step(); chk("R6 tp nop", bus, E_NOP); chk("R6 tp cke", sd_cke, 1);
    end
    step();
    chk("R6 self code", bus, E_AREF);
    chk("R6 self cke", sd_cke, 0);
    for (int i = 0; i < 6; i++) begin
      standby = (i % 2 == 0); tick = 1;
      step();
      chk("R7 self cke", sd_cke, 0);
      chk("R9 self noreq", ref_req, 0);
      chk("R6 self desel", sd_cs_n, 1);
    end
    standby = 0; tick = 0;
    // R8 exit
    cfg_self = 0; step();
    chk("R8 cke up", sd_cke, 1);
    chk("R8 nop", bus, E_NOP);
    for (int i = 1; i < wait_len(trc); i++) begin
      step(); chk("R8 gap nop", bus, E_NOP); chk("R8 gap noreq", ref_req, 0);
    end
    step(); chk("R8 idle", ref_req, 0);
    // R9 counter kept 9, one tick
    pulse_tick();
    chk("R9 resume", ref_req, 1);
    serve_aref("R9", 0);

    // R10 power-down holds entry
    cfg_pd = 1; cfg_self = 1;
    repeat (4) begin
      step(); chk("R10 held", ref_req, 0); chk("R10 cke", sd_cke, 1);
    end
    cfg_pd = 0; step();
    chk("R10 req", ref_req, 1);
    ref_gnt = 1; step(); ref_gnt = 0;
    chk("R10 pall", bus, E_PALL);
    repeat (TPC + 2) step();
    chk("R11 in self", sd_cke, 0);
    // R11 power-on reset clears self-refresh
    por_n = 0; cfg_self = 0; cfg_en = 0; step();
    chk("R11 cke", sd_cke, 1);
    chk("R11 bus", bus, E_NOP);
    por_n = 1; step();
    chk("R11 after", sd_cke, 1);
    chk("R11 noreq", ref_req, 0);
    cfg_en = 1; cnt_cmp = 4;
    for (int i = 0; i < 4; i++) begin
      pulse_tick();
      chk("R1 cleared count", ref_req, (i == 3) ? 1 : 0);
    end
    serve_aref("R1", 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule